// File: doc/BRIEF.md
# Audio CPU Wait-State Sequencer

This block paces the bus cycles of a small audio processor. The processor core asks for one bus cycle at a time. With each request it gives an address-valid flag and a 16-bit address. The block sorts the access into one of two classes. Idle cycles, the I/O register page and the enabled boot ROM window count as internal. Everything else counts as external, meaning RAM reached through the sound DSP. Each class has its own 2-bit divider select. The select of the chosen class then sets two numbers: how many base clocks the cycle is held busy, and how many of those clocks advance the on-chip timers.

`clk` is the processor base clock. It is produced outside this block by dividing the DSP master clock by 12, so about 2.048 MHz is derived from about 24.576 MHz. A request is taken only while the block is idle. The cycle then stays busy for its full stretch, and a one-clock done strobe marks the last busy clock. A timer-advance pulse is raised on each of the first busy clocks until the timer quota for that cycle has been spent.

At the two slowest settings the cycle takes longer than the timers advance. The timer quota keeps the power-of-two spacing while the stretch does not, so the two tables do not scale together.

Top module: `apu_wait_seq`

## Requirements
- R1: After reset the block is idle with `busy`, `cycle_done` and `timer_tick` low. Both divider selects are 0 and the boot ROM window is enabled.
- R2: A request with `addr_valid` low is an idle cycle and uses the internal select.
- R3: An address whose bits 15:4 equal 0x00F (0x00F0 to 0x00FF) uses the internal select. 0x00EF and 0x0100 use the external select.
- R4: An address at or above 0xFFC0 uses the internal select while the ROM window is enabled, and the external select while it is disabled. 0xFFBF is always external.
- R5: Every other valid address uses the external select.
- R6: Select values 0, 1, 2 and 3 give a stretch of 2, 4, 10 and 20 base clocks. The value is reported on `stretch_cnt` from the first busy clock on.
- R7: Select values 0, 1, 2 and 3 give a timer advance of 2, 4, 8 and 16 base clocks. The value is reported on `advance_cnt`.
- R8: An accepted cycle keeps `busy` high for exactly `stretch_cnt` clocks. `cycle_done` is high only on the last of those clocks, for one clock.
- R9: `timer_tick` is high on the first `advance_cnt` busy clocks of a cycle, back to back, and low for the rest of the cycle and while idle.
- R10: A request is accepted on a clock edge where `busy` is low. A request made while busy is ignored and does not change the current cycle's length, advance or class.
- R11: `cfg_wr` loads bits 7:6 of the mode word into the internal select, bits 5:4 into the external select, and `cfg_rom_en` into the ROM window enable. A write only affects cycles accepted after it, never the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request for a new bus cycle |
| addr_valid | input | 1 | Request carries an address (low means idle cycle) |
| addr | input | 16 | Bus address of the request |
| cfg_wr | input | 1 | Load the divider selects and ROM window enable |
| cfg_mode | input | 8 | Mode word: bits 7:6 internal select, bits 5:4 external select, others ignored |
| cfg_rom_en | input | 1 | Boot ROM window enable value to load |
| busy | output | 1 | A cycle is in progress |
| cycle_done | output | 1 | Last base clock of the current cycle |
| timer_tick | output | 1 | Timer advance pulse for this base clock |
| stretch_cnt | output | 5 | Base clocks of the latest accepted cycle |
| advance_cnt | output | 5 | Timer advance of the latest accepted cycle |
| cycle_internal | output | 1 | Latest accepted cycle used the internal select |

## Verification
The bench probes both edges of the I/O page (0x00EF, 0x00F0, 0x00FF, 0x0100) and the ROM boundary (0xFFBF, 0xFFC0) with the window both on and off. A wrong page compare or a wrong boundary would give those cycles the other class's stretch. Each select is set to a value different from its neighbour's, so that a swapped field or a table that scales the stretch as a power of two shows up as a 16 or 8 where 20 or 10 is due. The bench also counts ticks and busy clocks at the two slow settings. A design that tied ticks to the stretch would give 10 or 20 pulses, and an off-by-one counter would move the done strobe. It also fires requests and mode writes in the middle of a cycle. A design that accepted them would restart or reshape the cycle in progress.

// File: rtl/apu_wait_pkg.sv
`timescale 1ns/1ps
package apu_wait_pkg;

    localparam int SEL_W       = 2;
    localparam int MAX_STRETCH = 20;
    localparam int CNT_W       = $clog2(MAX_STRETCH + 1);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Bus cycle length: the two slowest settings do not divide evenly
    // into the base clock and end up at 10 and 20 clocks.
    function automatic cnt_t stretch_of(input sel_t s);
        cnt_t r;
        case (s)
            2'd0:    r = cnt_t'(2);
            2'd1:    r = cnt_t'(4);
            2'd2:    r = cnt_t'(10);
            default: r = cnt_t'(MAX_STRETCH);
        endcase
        return r;
    endfunction

    // Timer quota keeps the plain power-of-two spacing.
    function automatic cnt_t advance_of(input sel_t s);
        return cnt_t'(2) << s;
    endfunction

    typedef struct packed {
        logic busy;
        cnt_t remain;      // busy clocks left after the current one
        cnt_t ticks_left;  // timer pulses still owed this cycle
        cnt_t stretch;
        cnt_t advance;
        logic int_cls;
        sel_t int_sel;
        sel_t ext_sel;
        logic rom_en;
    } seq_state_t;

endpackage

// File: rtl/apu_wait_classify.sv
`timescale 1ns/1ps
module apu_wait_classify #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 4,
    parameter int IO_PAGE    = 'h00F,
    parameter int ROM_BASE   = 'hFFC0
) (
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    output logic              is_internal
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic io_hit;
    logic rom_hit;

    always_comb begin
        io_hit      = (addr[ADDR_W-1:PAGE_SHIFT] == PAGE_W'(IO_PAGE));
        rom_hit     = rom_en && (addr >= ADDR_W'(ROM_BASE));
        is_internal = !addr_valid || io_hit || rom_hit;
    end
endmodule

// File: rtl/apu_wait_lut.sv
`timescale 1ns/1ps
module apu_wait_lut
    import apu_wait_pkg::*;
(
    input  sel_t int_sel,
    input  sel_t ext_sel,
    input  logic use_int,
    output cnt_t stretch,
    output cnt_t advance
);
    sel_t pick;

    always_comb begin
        pick    = use_int ? int_sel : ext_sel;
        stretch = stretch_of(pick);
        advance = advance_of(pick);
    end
endmodule

// File: rtl/apu_wait_seq.sv
`timescale 1ns/1ps
module apu_wait_seq
    import apu_wait_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_mode,
    input  logic              cfg_rom_en,
    output logic              busy,
    output logic              cycle_done,
    output logic              timer_tick,
    output logic [CNT_W-1:0]  stretch_cnt,
    output logic [CNT_W-1:0]  advance_cnt,
    output logic              cycle_internal
);
    seq_state_t s_d, s_q;
    logic       cls_int;
    cnt_t       stretch_w;
    cnt_t       advance_w;

    apu_wait_classify #(.ADDR_W(ADDR_W)) i_classify (
        .addr_valid (addr_valid),
        .addr       (addr),
        .rom_en     (s_q.rom_en),
        .is_internal(cls_int)
    );

    apu_wait_lut i_lut (
        .int_sel (s_q.int_sel),
        .ext_sel (s_q.ext_sel),
        .use_int (cls_int),
        .stretch (stretch_w),
        .advance (advance_w)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_wr) begin
            s_d.int_sel = cfg_mode[7:6];
            s_d.ext_sel = cfg_mode[5:4];
            s_d.rom_en  = cfg_rom_en;
        end
        if (s_q.busy) begin
            if (s_q.remain == '0) s_d.busy   = 1'b0;
            else                  s_d.remain = s_q.remain - cnt_t'(1);
            if (s_q.ticks_left != '0) s_d.ticks_left = s_q.ticks_left - cnt_t'(1);
        end else if (req_valid) begin
            s_d.busy       = 1'b1;
            s_d.remain     = stretch_w - cnt_t'(1);
            s_d.ticks_left = advance_w;
            s_d.stretch    = stretch_w;
            s_d.advance    = advance_w;
            s_d.int_cls    = cls_int;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.rom_en  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy           = s_q.busy;
    assign cycle_done     = s_q.busy && (s_q.remain == '0);
    assign timer_tick     = s_q.busy && (s_q.ticks_left != '0);
    assign stretch_cnt    = s_q.stretch;
    assign advance_cnt    = s_q.advance;
    assign cycle_internal = s_q.int_cls;
endmodule

// File: rtl/apu_wait_chk.sv
`timescale 1ns/1ps
module apu_wait_chk
    import apu_wait_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       cycle_done,
    input logic       timer_tick,
    input cnt_t       stretch_cnt,
    input cnt_t       advance_cnt
);
    cnt_t len_q;
    cnt_t tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            len_q  <= '0;
            tick_q <= '0;
        end else begin
            len_q  <= len_q + cnt_t'(1);
            tick_q <= tick_q + cnt_t'(timer_tick);
        end
    end

    p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !busy);

    p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (len_q + cnt_t'(1) == stretch_cnt));

    p_tick_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (tick_q + cnt_t'(timer_tick) == advance_cnt));

    p_tick_front_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !timer_tick && !cycle_done) |=> !timer_tick);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cycle_done) |=> (busy && $stable(stretch_cnt) && $stable(advance_cnt)));

    p_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (stretch_cnt == 5'd2 || stretch_cnt == 5'd4 ||
                  stretch_cnt == 5'd10 || stretch_cnt == 5'd20));

    p_table_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(advance_cnt) == 1 && advance_cnt >= 5'd2 &&
                  advance_cnt <= stretch_cnt));
endmodule

bind apu_wait_seq apu_wait_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .cycle_done  (cycle_done),
    .timer_tick  (timer_tick),
    .stretch_cnt (stretch_cnt),
    .advance_cnt (advance_cnt)
);

// File: tb/test_apu_wait_seq.sv
`timescale 1ns/1ps
module test_apu_wait_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, addr_valid, cfg_wr, cfg_rom_en;
    logic [15:0] addr;
    logic [7:0]  cfg_mode;
    logic        busy, cycle_done, timer_tick, cycle_internal;
    logic [4:0]  stretch_cnt, advance_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    int m_int = 0, m_ext = 0, m_rom = 1;

    always #5 clk = ~clk;

    apu_wait_seq i_apu_wait_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_valid(addr_valid),
        .addr(addr), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_rom_en(cfg_rom_en),
        .busy(busy), .cycle_done(cycle_done), .timer_tick(timer_tick),
        .stretch_cnt(stretch_cnt), .advance_cnt(advance_cnt),
        .cycle_internal(cycle_internal)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_stretch(input int s);
        case (s)
            0: return 2;
            1: return 4;
            2: return 10;
            default: return 20;
        endcase
    endfunction

    function automatic int exp_adv(input int s);
        return 2 << s;
    endfunction

    function automatic bit exp_int(input bit av, input int a, input int rom);
        if (!av) return 1'b1;
        if (a >= 'h00F0 && a <= 'h00FF) return 1'b1;
        if (a >= 'hFFC0 && rom != 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string cls_tag(input bit av, input int a);
        if (!av) return "R2";
        if (a >= 'h00EF && a <= 'h0100) return "R3";
        if (a >= 'hFFBF) return "R4";
        return "R5";
    endfunction

    task automatic cfg(input int i, input int e, input int rom);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = {i[1:0], e[1:0], 4'b1010}; cfg_rom_en = rom[0];
        @(negedge clk);
        cfg_wr = 1'b0;
        m_int = i; m_ext = e; m_rom = rom;
    endtask

    // inject: 1 = stray request mid-cycle, 2 = mode write mid-cycle, 3 = both
    task automatic run(input bit av, input int a, input int inject);
        bit ei;
        int n, t, len, ticks, dcnt, dpos, ni, ne, nr;
        bit gap, order_bad;
        ei = exp_int(av, a, m_rom);
        n  = exp_stretch(ei ? m_int : m_ext);
        t  = exp_adv(ei ? m_int : m_ext);
        ni = $urandom_range(0, 3); ne = $urandom_range(0, 3); nr = $urandom_range(0, 1);
        @(negedge clk);
        req_valid = 1'b1; addr_valid = av; addr = a[15:0];
        @(negedge clk);
        req_valid = 1'b0;
        len = 0; ticks = 0; dcnt = 0; dpos = -1; gap = 0; order_bad = 0;
        while (busy && len < 64) begin
            if (timer_tick) begin
                ticks++;
                if (gap) order_bad = 1;
            end else gap = 1;
            if (cycle_done) begin
                dcnt++;
                dpos = len;
            end
            req_valid = (inject[0] && len == 0);
            if (req_valid) begin
                addr_valid = 1'b1;
                addr = 16'(32'h0000_0200 + $urandom_range(0, 255));
            end
            cfg_wr = (inject[1] && len == 0);
            if (cfg_wr) begin
                cfg_mode = {ni[1:0], ne[1:0], 4'b0000}; cfg_rom_en = nr[0];
            end
            len++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        cfg_wr    = 1'b0;
        if (inject[1]) begin
            m_int = ni; m_ext = ne; m_rom = nr;
        end
        chk(len == n, "R8 busy length", len, n);
        chk(dcnt == 1 && dpos == n - 1, "R8 done position", dpos, n - 1);
        chk(ticks == t, "R9 tick count", ticks, t);
        chk(!order_bad, "R9 ticks contiguous", order_bad, 0);
        chk(int'(stretch_cnt) == n, "R6 stretch", stretch_cnt, n);
        chk(int'(advance_cnt) == t, "R7 advance", advance_cnt, t);
        chk(cycle_internal == ei, cls_tag(av, a), cycle_internal, ei);
        chk(!timer_tick && !cycle_done, "R9 quiet when idle", timer_tick, 0);
        if (inject[0]) chk(len == n && !busy, "R10 stray request ignored", len, n);
        if (inject[1]) chk(len == n, "R11 mid-cycle write deferred", len, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int dir_addr [8] = '{'h00F0, 'h00FF, 'h00EF, 'h0100, 'hFFBF, 'hFFC0, 'hFFFF, 'h1234};
        void'($urandom(32'd7331));
        rst_n = 1'b0; req_valid = 1'b0; addr_valid = 1'b0; addr = '0;
        cfg_wr = 1'b0; cfg_mode = '0; cfg_rom_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cycle_done && !timer_tick, "R1 idle after reset", busy, 0);
        // reset selects are 0, ROM window on
        run(1'b0, 0, 0);
        chk(stretch_cnt == 5'd2 && cycle_internal, "R1 internal select 0", stretch_cnt, 2);
        run(1'b1, 'hFFC0, 0);
        chk(cycle_internal == 1'b1, "R1 ROM window enabled", cycle_internal, 1);
        run(1'b1, 'h0400, 0);
        chk(stretch_cnt == 5'd2, "R1 external select 0", stretch_cnt, 2);

        for (int s = 0; s < 4; s++) begin
            cfg(s, 3 - s, 1);
            run(1'b0, 0, 0);
            for (int k = 0; k < 8; k++) run(1'b1, dir_addr[k], 0);
            cfg(s, 3 - s, 0);
            run(1'b1, 'hFFC0, 0);
            run(1'b1, 'hFFFF, 1);
        end
        // R11: write mid-cycle, then the next cycle follows the new value
        cfg(3, 0, 1);
        run(1'b1, 'h0300, 2);
        run(1'b1, 'h0300, 0);
        run(1'b0, 0, 3);

        for (int k = 0; k < 200; k++) begin
            int pick, a;
            if ($urandom_range(0, 3) == 0)
                cfg($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1));
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = 'h00F0 + $urandom_range(0, 15);
                1: a = 'hFFB8 + $urandom_range(0, 71);
                2: a = 'h00E8 + $urandom_range(0, 31);
                default: a = $urandom_range(0, 65535);
            endcase
            if (a > 'hFFFF) a = 'hFFFF;
            run($urandom_range(0, 7) != 0, a, $urandom_range(0, 3));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule